// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block fills a bank of configuration bytes from a small three-wire serial EEPROM after reset. While reset is held it looks at the shared serial-clock/LED pad. A pull-up on that pad means a part is fitted, and a pull-down means none is. When a part is present, the block reads the whole 82-byte image one 16-bit word at a time. It keeps a running 8-bit sum of the bytes as they arrive. Only at the end does it decide what the host gets to see: the full image, or the loaded station-address bytes with defaults everywhere else.

A busy output stays high from the first cycle after reset until the image has been read. The bus side uses this signal to answer every host access with a retry. Two status flags report that the read finished and that the image was good. A small direct-access register lets software drive chip-select, serial clock and serial data itself, and sample the data coming back. Software uses this to program the EEPROM once the automatic load is over.

Top module: `cfg_autoload`

## Requirements
- R1: The value of `sk_pad_i` at the clock edge in the last cycle of reset decides presence. With 1, `busy_o` is high in the first cycle after reset and the read starts. With 0, there is no serial activity (`ee_cs_o`, `ee_sk_o` and `ee_di_o` stay 0), `busy_o` is 0, and both `done_o` and `valid_o` read 0.
- R2: Each word read raises `ee_cs_o` and sends 9 bits on `ee_di_o`, MSB first: 1, 1, 0, then the 6-bit word address. These bits change only while `ee_sk_o` is low. Then 16 data bits are sampled from `ee_do_i` on the next 16 rising `ee_sk_o` edges, MSB first.
- R3: Words 0 to 40 are read in ascending address order. `ee_sk_o` has a period of 2*CLK_HALF clock cycles, and `ee_cs_o` stays low for at least one full serial-clock period between words.
- R4: The low byte of word w becomes image byte 2w and its high byte becomes byte 2w+1. Image byte k appears on `cfg_o[8k+7:8k]`.
- R5: If the sum of all 82 bytes modulo 256 equals FFh, every byte of `cfg_o` takes its loaded value and `valid_o` becomes 1.
- R6: If the sum differs from FFh, `valid_o` is 0. Bytes 16 to 81 take their defaults (byte k defaults to (DEF_BASE + k) mod 256), and bytes 0 to 15 keep the values read.
- R7: With no EEPROM, bytes 16 to 81 hold their defaults and the flags stay 0.
- R8: `cfg_o` does not change until the read is complete. `done_o` rises in the same cycle that `busy_o` falls, and neither is ever high together with the other.
- R9: `busy_o` stays high for the whole automatic read and does not rise again before the next reset.
- R10: A write with `dir_we_i` stores `dir_wdata_i` as {enable, cs, sk, di}. When enable is 1 and the block is not busy, the pins follow the stored bits. `dir_rdata_o` reads {enable, cs, sk, di, data-in}, where data-in is `ee_do_i` delayed by one clock.
- R11: Writes to the direct-access register while `busy_o` is high are ignored.
- R12: After reset, `dir_rdata_o[4:1]` reads 0 and `done_o` and `valid_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sk_pad_i | input | 1 | Level of the shared serial-clock/LED pad, used for presence |
| ee_cs_o | output | 1 | EEPROM chip-select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | Load in progress; host accesses must be retried |
| done_o | output | 1 | Image read to completion |
| valid_o | output | 1 | Image checksum correct |
| dir_we_i | input | 1 | Write strobe for the direct-access register |
| dir_wdata_i | input | 4 | Direct-access write data {enable, cs, sk, di} |
| dir_rdata_o | output | 5 | Direct-access read data {enable, cs, sk, di, data-in} |
| cfg_o | output | 656 | Configuration bank, byte k at bits 8k+7:8k |

## Verification
The bound checker watches several things on every cycle. It checks that busy and done are never high together, that valid never appears without done, and that done and the end of busy are final until reset. It also checks that the bank moves only in the cycle busy falls, that the direct register is frozen while busy, and that chip-select has its full idle gap between words. Other behaviour can only be shown by the bench's scenarios. These are the serial command format and address order, the byte placement from each word, the choice between the full image and a partial restore of defaults, the absent-part case, and the pin hand-over in direct mode.

// File: rtl/cfg_autoload_pkg.sv
// Package: shared types and helpers for the configuration autoloader.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cfg_autoload_pkg;

    // States of the serial word reader.
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_GAP   = 2'd2,
        RD_DONE  = 2'd3
    } rd_state_t;

    // Direct-access register layout, MSB first.
    typedef struct packed {
        logic en;
        logic cs;
        logic sk;
        logic di;
    } dir_reg_t;

    // Default value of configuration byte k.
    function automatic logic [7:0] cfg_default(logic [7:0] base, int k);
        return base + 8'(k);
    endfunction

endpackage

// File: rtl/ee_tick_gen.sv
// Module: ee_tick_gen
// Emits a one-cycle enable every HALF system clocks while en_i is high.
// The reader uses it to pace each half period of the serial clock.
// Assumes: HALF >= 2. The counter restarts whenever en_i is low.
module ee_tick_gen #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divide counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/ee_word_reader.sv
// Module: ee_word_reader
// Runs three-wire serial READ frames for words 0..WORDS-1 in ascending order.
// Each frame sends start bit, opcode 10 and the address, then shifts in 16 bits.
// Serial data out changes while the clock is low; data in is sampled at rising edges.
// Assumes: tick_i is pulsed once per serial half period while active_o is high.
module ee_word_reader
    import cfg_autoload_pkg::*;
#(
    parameter int WORDS  = 41,
    parameter int ADDR_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        tick_i,
    input  logic        do_i,
    output logic        active_o,
    output logic        cs_o,
    output logic        sk_o,
    output logic        di_o,
    output logic        word_vld_o,
    output logic [15:0] word_o,
    output logic        fin_o
);
    localparam int CMD_BITS   = 3 + ADDR_W;
    localparam int FRAME_BITS = CMD_BITS + 16;
    localparam int BW         = $clog2(FRAME_BITS);
    localparam logic [BW-1:0]     LAST_BIT  = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0]     FIRST_DAT = BW'(CMD_BITS);
    localparam logic [ADDR_W-1:0] LAST_ADR  = ADDR_W'(WORDS - 1);

    rd_state_t             state_q;
    logic [BW-1:0]         bit_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [CMD_BITS-1:0]   cmd_q;
    logic [14:0]           sh_q;
    logic                  gap_q;

    assign active_o = (state_q == RD_SHIFT) || (state_q == RD_GAP);
    assign di_o     = cmd_q[CMD_BITS-1];

    // Frame sequencer: command shift-out, data shift-in, inter-word gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RD_IDLE;
            bit_q      <= '0;
            addr_q     <= '0;
            cmd_q      <= '0;
            sh_q       <= '0;
            gap_q      <= 1'b0;
            cs_o       <= 1'b0;
            sk_o       <= 1'b0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
            fin_o      <= 1'b0;
        end else begin
            word_vld_o <= 1'b0;
            fin_o      <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (start_i) begin
                        state_q <= RD_SHIFT;
                        cs_o    <= 1'b1;
                        bit_q   <= '0;
                        cmd_q   <= {3'b110, addr_q};
                    end
                end
                RD_SHIFT: begin
                    if (tick_i && !sk_o) begin
                        sk_o <= 1'b1;
                        if (bit_q >= FIRST_DAT) begin
                            sh_q <= {sh_q[13:0], do_i};
                        end
                        if (bit_q == LAST_BIT) begin
                            word_vld_o <= 1'b1;
                            word_o     <= {sh_q, do_i};
                        end
                    end else if (tick_i) begin
                        sk_o  <= 1'b0;
                        cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
                        if (bit_q == LAST_BIT) begin
                            cs_o  <= 1'b0;
                            bit_q <= '0;
                            if (addr_q == LAST_ADR) begin
                                state_q <= RD_DONE;
                                fin_o   <= 1'b1;
                            end else begin
                                state_q <= RD_GAP;
                                gap_q   <= 1'b0;
                                addr_q  <= addr_q + 1'b1;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                RD_GAP: begin
                    if (tick_i && gap_q) begin
                        state_q <= RD_SHIFT;
                        cs_o    <= 1'b1;
                        cmd_q   <= {3'b110, addr_q};
                    end else if (tick_i) begin
                        gap_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_image_bank.sv
// Module: cfg_image_bank
// Collects words into a staging image while summing the bytes, then commits
// the image to the visible bank once fin_i arrives. A bad sum restores the
// defaults above the station-address bytes and keeps those bytes as read.
// Assumes: at most WORDS word_vld_i pulses occur before fin_i.
module cfg_image_bank
    import cfg_autoload_pkg::*;
#(
    parameter int          WORDS      = 41,
    parameter int          ADDR_BYTES = 16,
    parameter logic [7:0]  DEF_BASE   = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_vld_i,
    input  logic [15:0]          word_i,
    input  logic                 fin_i,
    output logic [WORDS*16-1:0]  cfg_o,
    output logic                 valid_o,
    output logic                 done_o
);
    localparam int BYTES = 2 * WORDS;
    localparam int PW    = $clog2(WORDS);

    logic [WORDS*16-1:0] stage_q;
    logic [PW-1:0]       wptr_q;
    logic [7:0]          sum_q;
    logic                pass;

    assign pass = (sum_q == 8'hFF);

    // Staging store and running byte sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            wptr_q  <= '0;
            sum_q   <= '0;
        end else if (word_vld_i) begin
            stage_q[16*wptr_q +: 16] <= word_i;
            wptr_q <= wptr_q + 1'b1;
            sum_q  <= sum_q + word_i[7:0] + word_i[15:8];
        end
    end

    // Completion flags, taken at commit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else if (fin_i) begin
            valid_o <= pass;
            done_o  <= 1'b1;
        end
    end

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        logic [7:0] byte_q;
        assign cfg_o[8*k +: 8] = byte_q;
        if (k < ADDR_BYTES) begin : g_addr
            // Station-address byte: takes the read value on any commit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= 8'h00;
                end else if (fin_i) begin
                    byte_q <= stage_q[8*k +: 8];
                end
            end
        end else begin : g_cfg
            localparam logic [7:0] DEF = cfg_default(DEF_BASE, k);
            // Loadable byte: read value on a good image, default otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= DEF;
                end else if (fin_i) begin
                    byte_q <= pass ? stage_q[8*k +: 8] : DEF;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_autoload.sv
// Module: cfg_autoload (top)
// Looks at the pad during reset to detect the EEPROM, runs the word reader,
// commits the image bank and hands the serial pins to software on request.
// Assumes: CLK_HALF system clocks per serial half period respect the part's rate.
module cfg_autoload
    import cfg_autoload_pkg::*;
#(
    parameter int         CLK_HALF   = 32,
    parameter int         IMG_WORDS  = 41,
    parameter int         ADDR_W     = 6,
    parameter int         ADDR_BYTES = 16,
    parameter logic [7:0] DEF_BASE   = 8'h40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sk_pad_i,
    output logic                     ee_cs_o,
    output logic                     ee_sk_o,
    output logic                     ee_di_o,
    input  logic                     ee_do_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     valid_o,
    input  logic                     dir_we_i,
    input  logic [3:0]               dir_wdata_i,
    output logic [4:0]               dir_rdata_o,
    output logic [IMG_WORDS*16-1:0]  cfg_o
);
    localparam int IMG_BYTES = 2 * IMG_WORDS;

    logic        present_q;
    logic        busy_q;
    logic        do_q;
    dir_reg_t    dir_q;
    logic        rd_active, rd_tick, rd_cs, rd_sk, rd_di;
    logic        word_vld, fin;
    logic [15:0] word;

    // Presence capture during reset and the busy/retry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= sk_pad_i;
            busy_q    <= sk_pad_i;
        end else if (fin) begin
            busy_q <= 1'b0;
        end
    end

    // Direct-access register; writes are refused while loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            do_q  <= 1'b0;
        end else begin
            do_q <= ee_do_i;
            if (dir_we_i && !busy_q) begin
                dir_q <= dir_reg_t'(dir_wdata_i);
            end
        end
    end

    ee_tick_gen #(.HALF(CLK_HALF)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rd_active),
        .tick_o (rd_tick)
    );

    ee_word_reader #(.WORDS(IMG_WORDS), .ADDR_W(ADDR_W)) reader_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (present_q),
        .tick_i     (rd_tick),
        .do_i       (ee_do_i),
        .active_o   (rd_active),
        .cs_o       (rd_cs),
        .sk_o       (rd_sk),
        .di_o       (rd_di),
        .word_vld_o (word_vld),
        .word_o     (word),
        .fin_o      (fin)
    );

    cfg_image_bank #(
        .WORDS(IMG_WORDS), .ADDR_BYTES(ADDR_BYTES), .DEF_BASE(DEF_BASE)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld_i (word_vld),
        .word_i     (word),
        .fin_i      (fin),
        .cfg_o      (cfg_o),
        .valid_o    (valid_o),
        .done_o     (done_o)
    );

    // Pin ownership: software only when enabled and not loading.
    always_comb begin
        if (dir_q.en && !busy_q) begin
            ee_cs_o = dir_q.cs;
            ee_sk_o = dir_q.sk;
            ee_di_o = dir_q.di;
        end else begin
            ee_cs_o = rd_cs;
            ee_sk_o = rd_sk;
            ee_di_o = rd_di;
        end
    end

    assign busy_o      = busy_q;
    assign dir_rdata_o = {dir_q, do_q};
endmodule

// File: rtl/cfg_autoload_chk.sv
// Module: cfg_autoload_chk
// Property checker for cfg_autoload, attached by bind below.
// Assumes: synchronous active-low reset; CLK_HALF matches the bound instance.
module cfg_autoload_chk #(
    parameter int CLK_HALF = 32,
    parameter int CFG_BITS = 656
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy_i,
    input logic                done_i,
    input logic                valid_i,
    input logic                cs_i,
    input logic [3:0]          dirst_i,
    input logic [CFG_BITS-1:0] cfg_i
);
    logic [15:0] gap_q;

    // Counts cycles with chip-select low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            gap_q <= '1;
        else if (cs_i)         gap_q <= '0;
        else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
    end

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_i && done_i));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> done_i);
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_i) |-> $fell(busy_i));
    assert_valid_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> done_i);
    assert_busy_no_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> !busy_i);
    assert_dir_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(dirst_i));
    assert_cs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $rose(cs_i)) |-> (gap_q >= 16'(2 * CLK_HALF)));
endmodule

bind cfg_autoload cfg_autoload_chk #(
    .CLK_HALF (CLK_HALF),
    .CFG_BITS (IMG_BYTES * 8)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy_o),
    .done_i  (done_o),
    .valid_i (valid_o),
    .cs_i    (ee_cs_o),
    .dirst_i (dir_rdata_o[4:1]),
    .cfg_i   (cfg_o)
);

// File: tb/cfg_autoload_tb.sv
// Bench: scoreboard of expected items, a serial EEPROM model, and directed scenarios.
module cfg_autoload_tb_top;
    localparam int         HALF   = 4;
    localparam int         WORDS  = 41;
    localparam int         BYTES  = 82;
    localparam int         ABYTES = 16;
    localparam logic [7:0] DEFB   = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sk_pad = 1'b0;
    logic ee_cs, ee_sk, ee_di, ee_do;
    logic busy, done, valid;
    logic dir_we = 1'b0;
    logic [3:0] dir_wd = '0;
    logic [4:0] dir_rd;
    logic [BYTES*8-1:0] cfg;

    always #4 clk = ~clk;

    cfg_autoload #(.CLK_HALF(HALF), .IMG_WORDS(WORDS), .DEF_BASE(DEFB)) dut_i (
        .clk(clk), .rst_n(rst_n), .sk_pad_i(sk_pad),
        .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do),
        .busy_o(busy), .done_o(done), .valid_o(valid),
        .dir_we_i(dir_we), .dir_wdata_i(dir_wd), .dir_rdata_o(dir_rd),
        .cfg_o(cfg)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [WORDS];
    logic [7:0]  img [BYTES];
    logic        m_do = 1'b0;
    logic        frc_en = 1'b0;
    logic        frc_val = 1'b0;
    logic [8:0]  m_cmd = '0;
    int          m_cnt = 0;
    int          m_ptr = 0;
    int          exp_addr = 0;

    assign ee_do = frc_en ? frc_val : m_do;

    // Serial slave: takes 9 command bits, then presents 16 data bits MSB first.
    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            m_cnt = 0;
        end else begin
            if (m_cnt < 9) m_cmd = {m_cmd[7:0], ee_di};
            m_cnt++;
            if (m_cnt == 9) begin
                if (busy) begin
                    check("R2 start+opcode", {5'd0, m_cmd[8:6]}, 8'h06);
                    check("R3 address order", {2'd0, m_cmd[5:0]}, 8'(exp_addr));
                    exp_addr++;
                end
                m_ptr = 14;
                m_do  = (m_cmd[5:0] < 6'(WORDS)) ? mem[m_cmd[5:0]][15] : 1'b0;
            end else if (m_cnt > 9 && m_ptr >= 0) begin
                m_do = (m_cmd[5:0] < 6'(WORDS)) ? mem[m_cmd[5:0]][m_ptr] : 1'b0;
                m_ptr--;
            end
        end
    end

    // ---------------- Scoreboard ----------------
    typedef struct {
        string      req;
        int         kind;
        int         idx;
        logic [7:0] exp;
    } item_t;
    item_t q[$];
    item_t it;
    logic  chk_req = 1'b0;

    task automatic push(string req, int kind, int idx, logic [7:0] exp);
        item_t e;
        e.req = req; e.kind = kind; e.idx = idx; e.exp = exp;
        q.push_back(e);
    endtask

    function automatic logic [7:0] actual(int kind, int idx);
        case (kind)
            0:       return cfg[8*idx +: 8];
            1:       return {7'd0, valid};
            2:       return {7'd0, done};
            3:       return {7'd0, busy};
            4:       return {3'd0, dir_rd};
            default: return {5'd0, ee_cs, ee_sk, ee_di};
        endcase
    endfunction

    // Monitor: pops and compares every queued item at a falling edge.
    always begin
        @(negedge clk);
        if (chk_req) begin
            while (q.size() > 0) begin
                it = q.pop_front();
                check(it.req, actual(it.kind, it.idx), it.exp);
            end
            chk_req = 1'b0;
        end
    end

    task automatic run_check();
        chk_req = 1'b1;
        wait (chk_req == 1'b0);
    endtask

    // ---------------- Drivers ----------------
    task automatic build_image(int mul, int add, bit good);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < BYTES - 1; i++) begin
            img[i] = 8'(i * mul + add);
            s = s + img[i];
        end
        img[BYTES-1] = good ? (8'hFF - s) : (8'hFF - s + 8'h01);
        for (int w = 0; w < WORDS; w++) mem[w] = {img[2*w+1], img[2*w]};
    endtask

    task automatic apply_reset(bit present);
        @(negedge clk);
        rst_n = 1'b0; sk_pad = present; dir_we = 1'b0; frc_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_addr = 0;
    endtask

    task automatic dir_write(logic [3:0] d);
        @(negedge clk);
        dir_we = 1'b1; dir_wd = d;
        @(negedge clk);
        dir_we = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check("R8 busy low when done rises", {7'd0, busy}, 8'h00);
        check("R8 done seen", {7'd0, done}, 8'h01);
    endtask

    task automatic expect_defaults(string req);
        for (int k = ABYTES; k < BYTES; k++) push(req, 0, k, DEFB + 8'(k));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Good image, first pattern.
        build_image(7, 3, 1'b1);
        apply_reset(1'b1);
        push("R12 done after reset", 2, 0, 8'h00);
        push("R12 valid after reset", 1, 0, 8'h00);
        push("R12 direct reg after reset", 4, 0, {3'd0, 4'h0, ee_do});
        push("R1 busy after present reset", 3, 0, 8'h01);
        run_check();
        repeat (2000) @(negedge clk);
        push("R9 busy mid-load", 3, 0, 8'h01);
        expect_defaults("R8 bank unchanged mid-load");
        run_check();
        wait_done();
        for (int k = 0; k < BYTES; k++) push("R4 R5 loaded byte", 0, k, img[k]);
        push("R5 valid", 1, 0, 8'h01);
        push("R9 busy after load", 3, 0, 8'h00);
        run_check();

        // Bad checksum, with a direct write attempted while busy.
        build_image(13, 91, 1'b0);
        apply_reset(1'b1);
        repeat (20) @(negedge clk);
        dir_write(4'b1001);
        push("R11 pins still owned by reader", 3, 0, 8'h01);
        run_check();
        wait_done();
        for (int k = 0; k < ABYTES; k++) push("R6 address byte kept", 0, k, img[k]);
        expect_defaults("R6 defaults restored");
        push("R6 valid clear", 1, 0, 8'h00);
        push("R6 done set", 2, 0, 8'h01);
        push("R11 write ignored", 4, 0, {3'd0, 4'h0, ee_do});
        run_check();

        // No EEPROM.
        apply_reset(1'b0);
        repeat (200) @(negedge clk);
        push("R7 busy", 3, 0, 8'h00);
        push("R7 done", 2, 0, 8'h00);
        push("R7 valid", 1, 0, 8'h00);
        push("R1 no serial activity", 5, 0, 8'h00);
        expect_defaults("R7 defaults");
        run_check();

        // Direct access.
        frc_en = 1'b1; frc_val = 1'b1;
        dir_write(4'b1110);
        @(negedge clk);
        push("R10 pins follow register", 5, 0, 8'h06);
        push("R10 readback data-in 1", 4, 0, 8'h1D);
        run_check();
        frc_val = 1'b0;
        repeat (2) @(negedge clk);
        push("R10 readback data-in 0", 4, 0, 8'h1C);
        run_check();
        dir_write(4'b0101);
        push("R10 disabled pins released", 5, 0, 8'h00);
        push("R10 disabled readback", 4, 0, 8'h0A);
        run_check();
        frc_en = 1'b0;

        // Good image, second pattern.
        build_image(29, 200, 1'b1);
        apply_reset(1'b1);
        wait_done();
        for (int k = 0; k < BYTES; k++) push("R5 second image byte", 0, k, img[k]);
        push("R5 valid second image", 1, 0, 8'h01);
        run_check();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule